// File: doc/BRIEF.md
# Framed Serial Byte Slave with Handshake Status

This block is a serial slave that moves one byte per transfer between an external master and two byte streams inside the chip. On its inner side it offers bytes from a receive source, which raises a flag while a byte is waiting. It delivers bytes into a transmit sink, which raises a flag while it has room. It also holds two interrupt-enable bits that the master can read and write through a small status register.

Each transfer is an eleven-bit frame. The select line is active-high and stays high for the whole frame. The master sends a direction bit, then a register-select bit, then eight data bits with the MSB first. The data bits go out on the slave output for reads and come in on the slave input for writes. The frame ends with one handshake bit from the slave. A 0 tells the master that the byte it read was fresh, or that its write was taken. A 1 tells the master to retry. The serial lines are sampled with the system clock, which must run several times faster than the serial clock. The master must drop select for at least one serial clock period between frames.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset the serial output is 0, no pop or push pulse is given, both interrupt-enable bits are 0, and the held last byte is 0x00.
- R2: Input bits are taken on rising serial-clock edges while select is high. The first bit is the direction: 1 means read and 0 means write.
- R3: The second bit picks the register: 0 means the data register and 1 means the status register.
- R4: On a read, the eight data bits appear on the serial output MSB first. D7 is driven after the falling edge that follows the register-select bit, and each later bit is driven after the next falling edge. The output changes only after a falling serial-clock edge or when select is low.
- R5: A data read with a byte waiting returns that byte and gives a handshake bit of 0. It gives exactly one `rx_pop` pulse, which comes when the last data bit is clocked.
- R6: A data read with no byte waiting returns the last byte that was popped (0x00 after reset). It gives a handshake bit of 1 and no pop.
- R7: A data write with room in the sink gives one `tx_push` pulse carrying the received byte (MSB first on the input) and a handshake bit of 0.
- R8: A data write with the sink full gives no push and a handshake bit of 1.
- R9: A status read returns these bits: bit 0 = not `rx_valid`, bit 1 = not `tx_ready`, bit 4 = receive interrupt enable, bit 5 = transmit interrupt enable. All other bits read 0, and the handshake bit is 0.
- R10: A status write loads only bits 4 and 5 into the enables. All other written bits are ignored, and the handshake bit is 0.
- R11: If select drops before the last data bit is clocked, the frame has no effect. There is no pop, no push and no change to the enables.
- R12: While select is low the serial output is 0, and a new frame starts again from the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_sel | input | 1 | Frame select, active high |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |
| rx_valid | input | 1 | Receive source holds a byte |
| rx_data | input | 8 | Byte offered by the receive source |
| rx_pop | output | 1 | One-cycle pulse that takes the offered byte |
| tx_ready | input | 1 | Transmit sink has room |
| tx_data | output | 8 | Byte delivered to the sink |
| tx_push | output | 1 | One-cycle pulse that writes `tx_data` |

## Verification
The assertions assume that the receive source keeps `rx_valid` and `rx_data` steady from the register-select bit until the frame ends. They also assume that the serial clock is slow enough that each of its levels lasts longer than the synchronizer delay. The stimulus keeps each serial-clock half period at eight system clocks. It sets the inner flags before raising select and leaves them unchanged until select falls. It gives a gap of several cycles between frames. Aborted frames are cut off at chosen bit counts, and each is followed by full frames that show whether any state was touched.

// File: rtl/spi_frame_slave.sv
module spi_frame_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_sel,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_pop,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_push
);
  localparam int HDR_BITS = 2;
  localparam int LAST_DAT = HDR_BITS + BYTE_W - 1;
  localparam int FRAME_N  = LAST_DAT + 1;
  localparam int CW       = $clog2(FRAME_N + 1);
  localparam int IW       = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sck_q, sel_q, mosi_q;
  logic                   sck_d;
  logic                   sck_s, sel_s, mosi_s, sck_rise, sck_fall;
  logic [CW-1:0]          cnt;
  logic                   rw, reg_sel, fresh, hs_bit;
  logic [BYTE_W-1:0]      shreg, last_byte, byte_in, status_word;
  logic [1:0]             irq_en;
  logic [IW-1:0]          out_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      sel_q  <= '0;
      mosi_q <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[SYNC_STAGES-2:0], spi_sck};
      sel_q  <= {sel_q[SYNC_STAGES-2:0], spi_sel};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], spi_mosi};
      sck_d  <= sck_q[SYNC_STAGES-1];
    end

  assign sck_s    = sck_q[SYNC_STAGES-1];
  assign sel_s    = sel_q[SYNC_STAGES-1];
  assign mosi_s   = mosi_q[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign byte_in  = {shreg[BYTE_W-2:0], mosi_s};
  assign out_idx  = IW'(LAST_DAT - int'(cnt));

  always_comb begin
    status_word    = '0;
    status_word[0] = ~rx_valid;
    status_word[1] = ~tx_ready;
    status_word[5:4] = irq_en;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= '0;
      rw        <= 1'b0;
      reg_sel   <= 1'b0;
      fresh     <= 1'b0;
      hs_bit    <= 1'b0;
      shreg     <= '0;
      last_byte <= '0;
      irq_en    <= '0;
      spi_miso  <= 1'b0;
      rx_pop    <= 1'b0;
      tx_push   <= 1'b0;
      tx_data   <= '0;
    end else begin
      rx_pop  <= 1'b0;
      tx_push <= 1'b0;
      if (!sel_s) begin
        cnt      <= '0;
        spi_miso <= 1'b0;
      end else begin
        if (sck_rise) begin
          if (int'(cnt) != FRAME_N) cnt <= cnt + 1'b1;
          if (cnt == 0) begin
            rw <= mosi_s;
          end else if (cnt == 1) begin
            reg_sel <= mosi_s;
            if (rw) begin
              if (mosi_s) begin
                shreg <= status_word;
                fresh <= 1'b0;
              end else if (rx_valid) begin
                shreg <= rx_data;
                fresh <= 1'b1;
              end else begin
                shreg <= last_byte;
                fresh <= 1'b0;
              end
            end
          end else if (int'(cnt) == LAST_DAT) begin
            case ({rw, reg_sel})
              2'b00: begin
                if (tx_ready) begin
                  tx_push <= 1'b1;
                  tx_data <= byte_in;
                end
                hs_bit <= ~tx_ready;
              end
              2'b01: begin
                irq_en <= byte_in[5:4];
                hs_bit <= 1'b0;
              end
              2'b10: begin
                if (fresh) begin
                  rx_pop    <= 1'b1;
                  last_byte <= shreg;
                end
                hs_bit <= ~fresh;
              end
              default: hs_bit <= 1'b0;
            endcase
          end else if (!rw && int'(cnt) < LAST_DAT) begin
            shreg <= byte_in;
          end
        end
        if (sck_fall) begin
          if (rw && cnt >= HDR_BITS && int'(cnt) <= LAST_DAT)
            spi_miso <= shreg[out_idx];
          else if (int'(cnt) == FRAME_N)
            spi_miso <= hs_bit;
          else
            spi_miso <= 1'b0;
        end
      end
    end

  // R5
  pop_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_valid);

  // R5
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_pop);

  // R7
  push_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> tx_ready);

  // R11
  side_effect_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop || tx_push) |-> $past(sel_s));

  // R4
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso != $past(spi_miso)) |-> ($past(sck_fall) || !$past(sel_s)));

  // R11
  no_pop_push_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_pop, tx_push}));
endmodule

// File: tb/spi_frame_slave_tb.sv
module spi_frame_slave_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_sel = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso;
  logic       rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [7:0] tx_data;
  logic       rx_pop, tx_push;

  int errors = 0, checks = 0;
  int pop_cnt = 0, push_cnt = 0;
  logic [7:0] push_val = 8'h00;

  always #2 clk = ~clk;

  spi_frame_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_sel(spi_sel),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_pop(rx_pop), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_push(tx_push)
  );

  always @(negedge clk) begin
    if (rx_pop) pop_cnt++;
    if (tx_push) begin
      push_cnt++;
      push_val = tx_data;
    end
  end

  typedef struct packed {
    logic       rw;
    logic       ad;
    logic [7:0] wd;
    logic       rxv;
    logic [7:0] rxd;
    logic       txr;
    logic [7:0] erd;
    logic       est;
    logic       epop;
    logic       epush;
    logic [7:0] epv;
  } vec_t;

  // fields: rw ad wd rxv rxd txr | exp read byte, handshake, pop, push, pushed byte
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    {1'b1,1'b1,8'h00,1'b0,8'h00,1'b1, 8'h01,1'b0,1'b0,1'b0,8'h00},
    {1'b1,1'b0,8'h00,1'b0,8'h00,1'b1, 8'h00,1'b1,1'b0,1'b0,8'h00},
    {1'b1,1'b0,8'h00,1'b1,8'hA5,1'b1, 8'hA5,1'b0,1'b1,1'b0,8'h00},
    {1'b1,1'b0,8'h00,1'b0,8'h00,1'b1, 8'hA5,1'b1,1'b0,1'b0,8'h00},
    {1'b0,1'b0,8'h3C,1'b0,8'h00,1'b1, 8'h00,1'b0,1'b0,1'b1,8'h3C},
    {1'b0,1'b0,8'h81,1'b0,8'h00,1'b0, 8'h00,1'b1,1'b0,1'b0,8'h00},
    {1'b0,1'b1,8'hFF,1'b0,8'h00,1'b1, 8'h00,1'b0,1'b0,1'b0,8'h00},
    {1'b1,1'b1,8'h00,1'b1,8'h11,1'b0, 8'h32,1'b0,1'b0,1'b0,8'h00},
    {1'b0,1'b1,8'h10,1'b0,8'h00,1'b1, 8'h00,1'b0,1'b0,1'b0,8'h00},
    {1'b1,1'b1,8'h00,1'b0,8'h00,1'b1, 8'h11,1'b0,1'b0,1'b0,8'h00},
    {1'b1,1'b0,8'h00,1'b1,8'h5E,1'b1, 8'h5E,1'b0,1'b1,1'b0,8'h00},
    {1'b0,1'b0,8'hC3,1'b0,8'h00,1'b1, 8'h00,1'b0,1'b0,1'b1,8'hC3},
    {1'b1,1'b1,8'h00,1'b1,8'h00,1'b1, 8'h10,1'b0,1'b0,1'b0,8'h00}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2, R3: direction bit, then register bit, then data MSB first, then handshake
  task automatic frame(input logic rw, input logic ad, input logic [7:0] wd, input int nbits,
                       output logic [7:0] rd, output logic st);
    rd = 8'h00;
    st = 1'b0;
    spi_sel = 1'b1;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i == 0) spi_mosi = rw;
      else if (i == 1) spi_mosi = ad;
      else if (i <= 9) spi_mosi = wd[9-i];
      else spi_mosi = 1'b0;
      wait_clk(HALF);
      if (i >= 2 && i <= 9) rd[9-i] = spi_miso;
      if (i == 10) st = spi_miso;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
    wait_clk(HALF);
    spi_sel = 1'b0;
    wait_clk(HALF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic st;
    string tag;
    wait_clk(5);
    // R1
    chk("R1", "miso in reset", spi_miso, 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R1", "miso after reset", spi_miso, 0);
    chk("R1", "no pulses after reset", {rx_pop, tx_push}, 0);

    for (int v = 0; v < NV; v++) begin
      rx_valid = VEC[v].rxv;
      rx_data  = VEC[v].rxd;
      tx_ready = VEC[v].txr;
      pop_cnt  = 0;
      push_cnt = 0;
      wait_clk(2);
      if (v == 0) tag = "R1";
      else if (VEC[v].rw && VEC[v].ad) tag = "R9";
      else if (VEC[v].rw) tag = VEC[v].est ? "R6" : "R5";
      else if (VEC[v].ad) tag = "R10";
      else tag = VEC[v].est ? "R8" : "R7";
      frame(VEC[v].rw, VEC[v].ad, VEC[v].wd, 11, rd, st);
      chk(tag, $sformatf("vec %0d read byte (R4)", v), rd, VEC[v].erd);
      chk(tag, $sformatf("vec %0d handshake", v), st, VEC[v].est);
      chk(tag, $sformatf("vec %0d pops", v), pop_cnt, VEC[v].epop);
      chk(tag, $sformatf("vec %0d pushes", v), push_cnt, VEC[v].epush);
      if (VEC[v].epush) chk(tag, $sformatf("vec %0d pushed byte", v), push_val, VEC[v].epv);
      chk("R12", $sformatf("vec %0d idle miso", v), spi_miso, 0);
    end

    // R11: aborted frames leave everything untouched
    rx_valid = 1'b1;
    rx_data  = 8'h77;
    tx_ready = 1'b1;
    pop_cnt  = 0;
    push_cnt = 0;
    frame(1'b0, 1'b0, 8'h99, 9, rd, st);
    chk("R11", "aborted write pushes", push_cnt, 0);
    frame(1'b1, 1'b0, 8'h00, 6, rd, st);
    chk("R11", "aborted read pops", pop_cnt, 0);
    frame(1'b0, 1'b1, 8'h20, 9, rd, st);
    frame(1'b1, 1'b1, 8'h00, 11, rd, st);
    chk("R11", "enables after aborted status write", rd, 8'h10);
    chk("R12", "restart after abort handshake", st, 0);
    frame(1'b1, 1'b0, 8'h00, 11, rd, st);
    chk("R11", "byte kept through aborted read", rd, 8'h77);
    chk("R11", "single pop after aborts", pop_cnt, 1);

    // R6: empty source repeats the last popped byte, then idle output returns to 0
    rx_valid = 1'b0;
    frame(1'b1, 1'b0, 8'h00, 11, rd, st);
    chk("R6", "stale byte", rd, 8'h77);
    chk("R6", "stale handshake", st, 1);
    chk("R12", "miso low after stale frame", spi_miso, 0);
    // R10: ignored bits stay out of the status read
    frame(1'b0, 1'b1, 8'hCF, 11, rd, st);
    chk("R10", "handshake of status write", st, 0);
    frame(1'b1, 1'b1, 8'h00, 11, rd, st);
    chk("R10", "only enable bits loaded", rd, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule